// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel

This block is a single copy channel. It moves a run of bytes from one place in memory to another. Software sets it up through a 32-bit register port with word offsets. It writes a source address, a destination address and a byte count, then sets the run bit. The engine then walks the destination one word at a time. For each destination word it fetches the one or two source words that hold the needed bytes. It shifts those bytes into their lanes and writes the word back, with byte enables covering only the bytes that belong to the copy. Source, destination and length may each sit on any byte boundary.

The memory side is a plain request/acknowledge master. At most one access is outstanding, and each access carries one 32-bit word. When the last byte has been written, the run bit drops by itself and a completion flag is set. That flag drives the interrupt line whenever the interrupt-enable bit is set. Software polls the run bit to learn when the engine is idle. It can stop the engine in three ways: a one-shot warm restart, a held hard reset that also wipes the programmed setup, and a held flush.

Top module: `dma_copy_chan`

## Requirements
- R1: The register offsets are fixed as follows:
  - 0x00: completion flag (bit 0)
  - 0x04: interrupt enable (bit 0)
  - 0x08: run (bit 0)
  - 0x0C: restart/reset (bit 0 warm, bit 1 hard)
  - 0x14: flush (bit 0)
  - 0x1C: source low
  - 0x20: destination low
  - 0x24: length
  - 0x28: auxiliary length
  - 0x60: source high
  - 0x64: destination high

  After reset every register reads 0. The length register keeps only its low 28 bits, and the upper 4 bits read 0. The other setup registers read back what was written.
- R2: Writing 1 to run bit 0 while idle starts a copy. Run bit 0 reads 1 from the next cycle until the copy ends, then reads 0 without any software action.
- R3: After a copy, every byte in [dst, dst+len) equals the source byte at the same offset, for any byte alignment of source, destination and length. No byte outside that range is changed.
- R4: Only one memory access is outstanding at a time. Once mem_req is raised, mem_we, mem_addr, mem_wdata and mem_be stay fixed until mem_ack. Each access carries one 32-bit word.
- R5: The completion flag is set when a copy ends. Writing 0 to flag bit 0 clears it. Writing 1 to it has no effect.
- R6: irq is high exactly when both the completion flag and interrupt-enable bit 0 are 1.
- R7: A copy of length 0 finishes without any memory access and still sets the completion flag.
- R8: While the run bit reads 1, writes to the source, destination and length registers are ignored. Those registers keep their earlier values, and the copy in flight uses them unchanged.
- R9: Writing 1 to reset bit 0 abandons any copy. From the next cycle run reads 0, no further memory access is made and the flag is not set. The bit itself reads 0, and the programmed setup is kept.
- R10: While reset bit 1 is 1, the engine stays idle and start requests are ignored. The address, length, flag and interrupt-enable registers read 0. Bit 1 reads back as written.
- R11: While flush bit 0 is 1, any copy is stopped, run reads 0 and start requests are ignored. The bit reads back 1 until software writes 0.
- R12: The memory address is the 64-bit value {high, low} plus the byte progress, with the low 2 bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables, one per lane |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The handshake assertions assume three things about the memory side: it raises mem_ack only while mem_req is high, it presents read data in the same cycle as that acknowledge, and it never acknowledges two accesses for one request. The bench memory model meets this by deciding each acknowledge half a cycle after the request settles. Its wait rotates through 0, 1 and 2 cycles, so both held and immediate grants occur. The register-side assertions assume one register write per cycle, with the run write never issued in the same cycle as a setup write. The bench tasks issue exactly one write per cycle. Source and destination buffers never overlap, and every copy stays inside a 512-byte window that the model decodes from the low address bits.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

    localparam int REG_AW = 7;

    // Register byte offsets (software decodes these)
    localparam logic [REG_AW-1:0] OFS_IFLAG   = 7'h00;
    localparam logic [REG_AW-1:0] OFS_IEN     = 7'h04;
    localparam logic [REG_AW-1:0] OFS_RUN     = 7'h08;
    localparam logic [REG_AW-1:0] OFS_RST     = 7'h0C;
    localparam logic [REG_AW-1:0] OFS_FLUSH   = 7'h14;
    localparam logic [REG_AW-1:0] OFS_SRC_LO  = 7'h1C;
    localparam logic [REG_AW-1:0] OFS_DST_LO  = 7'h20;
    localparam logic [REG_AW-1:0] OFS_LEN     = 7'h24;
    localparam logic [REG_AW-1:0] OFS_LEN_AUX = 7'h28;
    localparam logic [REG_AW-1:0] OFS_SRC_HI  = 7'h60;
    localparam logic [REG_AW-1:0] OFS_DST_HI  = 7'h64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_RD_LO,
        ST_RD_HI,
        ST_WR
    } eng_state_e;

endpackage

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [OFF_W:0]    chunk,
    output logic [DATA_W-1:0] wdata,
    output logic [NB-1:0]     be
);
    logic [2*DATA_W-1:0] joined;
    logic [DATA_W-1:0]   first_bytes;

    always_comb begin
        joined      = {hi_word, lo_word} >> {src_off, 3'b000};
        first_bytes = joined[DATA_W-1:0];
        wdata       = first_bytes << {dst_off, 3'b000};
    end

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [OFF_W:0] lane_idx;
        logic [OFF_W:0] lane_lo;
        logic [OFF_W:0] lane_hi;
        assign lane_idx = (OFF_W+1)'(j);
        assign lane_lo  = {1'b0, dst_off};
        assign lane_hi  = lane_lo + chunk;
        assign be[j]    = (lane_idx >= lane_lo) && (lane_idx < lane_hi);
    end

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 28,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB),
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] start_src,
    input  logic [ADDR_W-1:0] start_dst,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NB-1:0]     mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [OFF_W:0] LANES = (OFF_W+1)'(NB);

    typedef struct packed {
        eng_state_e        state;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  rem;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic              cache_vld;
        logic [WA_W-1:0]   cache_wa;
        logic [DATA_W-1:0] cache_data;
    } eng_t;

    eng_t q, d;

    logic [OFF_W-1:0] src_off, dst_off;
    logic [WA_W-1:0]  w0, w1, dst_wa, addr_wa;
    logic [OFF_W:0]   room, chunk;
    logic             span_two, lo_hit;
    logic [DATA_W-1:0] pack_data;
    logic [NB-1:0]     pack_be;

    always_comb begin
        src_off  = q.src[OFF_W-1:0];
        dst_off  = q.dst[OFF_W-1:0];
        w0       = q.src[ADDR_W-1:OFF_W];
        w1       = w0 + WA_W'(1);
        dst_wa   = q.dst[ADDR_W-1:OFF_W];
        room     = LANES - {1'b0, dst_off};
        chunk    = (q.rem < LEN_W'(room)) ? q.rem[OFF_W:0] : room;
        span_two = ({1'b0, src_off} + chunk) > LANES;
        lo_hit   = q.cache_vld && (q.cache_wa == w0);
    end

    dma_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .lo_word (q.lo),
        .hi_word (q.hi),
        .src_off (src_off),
        .dst_off (dst_off),
        .chunk   (chunk),
        .wdata   (pack_data),
        .be      (pack_be)
    );

    always_comb begin
        d       = q;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        addr_wa = w0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.src       = start_src;
                    d.dst       = start_dst;
                    d.rem       = start_len;
                    d.cache_vld = 1'b0;
                    d.state     = (start_len == '0) ? ST_ZERO : ST_RD_LO;
                end
            end
            ST_ZERO: begin
                done    = 1'b1;
                d.state = ST_IDLE;
            end
            ST_RD_LO: begin
                if (lo_hit) begin
                    d.lo    = q.cache_data;
                    d.state = span_two ? ST_RD_HI : ST_WR;
                end else begin
                    mem_req = 1'b1;
                    if (mem_ack) begin
                        d.lo         = mem_rdata;
                        d.cache_vld  = 1'b1;
                        d.cache_wa   = w0;
                        d.cache_data = mem_rdata;
                        d.state      = span_two ? ST_RD_HI : ST_WR;
                    end
                end
            end
            ST_RD_HI: begin
                mem_req = 1'b1;
                addr_wa = w1;
                if (mem_ack) begin
                    d.hi         = mem_rdata;
                    d.cache_vld  = 1'b1;
                    d.cache_wa   = w1;
                    d.cache_data = mem_rdata;
                    d.state      = ST_WR;
                end
            end
            ST_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                addr_wa = dst_wa;
                if (mem_ack) begin
                    d.src = q.src + ADDR_W'(chunk);
                    d.dst = q.dst + ADDR_W'(chunk);
                    d.rem = q.rem - LEN_W'(chunk);
                    if (q.cache_vld && (q.cache_wa == dst_wa)) begin
                        d.cache_vld = 1'b0;
                    end
                    if (q.rem == LEN_W'(chunk)) begin
                        done    = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_RD_LO;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (abort) begin
            d.state = ST_IDLE;
            done    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != ST_IDLE);
    assign mem_addr  = {addr_wa, {OFF_W{1'b0}}};
    assign mem_wdata = pack_data;
    assign mem_be    = mem_we ? pack_be : '0;

    // R4: an unacknowledged request holds still
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=>
            (mem_req && $stable(mem_we) && $stable(mem_addr)
             && $stable(mem_wdata) && $stable(mem_be)));

    // R3: every write beat enables at least one lane
    a_r3_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0));

    // R7: an empty copy never touches memory
    a_r7_zero_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (start_len == '0)) |=> !mem_req);

    // R9: any stop request leaves the engine idle
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 28,
    localparam int HI_W  = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              start,
    output logic              abort,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [LEN_W-1:0]  len
);
    typedef struct packed {
        logic              iflag;
        logic              ien;
        logic              hard;
        logic              flush;
        logic [31:0]       src_lo;
        logic [31:0]       dst_lo;
        logic [HI_W-1:0]   src_hi;
        logic [HI_W-1:0]   dst_hi;
        logic [LEN_W-1:0]  len;
        logic [31:0]       len_aux;
    } cfg_t;

    cfg_t q, d;
    logic warm, run_req;

    always_comb begin
        d       = q;
        warm    = 1'b0;
        run_req = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_IFLAG:   if (!reg_wdata[0]) d.iflag = 1'b0;
                OFS_IEN:     d.ien = reg_wdata[0];
                OFS_RUN:     run_req = reg_wdata[0];
                OFS_RST: begin
                    warm   = reg_wdata[0];
                    d.hard = reg_wdata[1];
                end
                OFS_FLUSH:   d.flush = reg_wdata[0];
                OFS_SRC_LO:  if (!eng_busy) d.src_lo = reg_wdata;
                OFS_DST_LO:  if (!eng_busy) d.dst_lo = reg_wdata;
                OFS_SRC_HI:  if (!eng_busy) d.src_hi = reg_wdata[HI_W-1:0];
                OFS_DST_HI:  if (!eng_busy) d.dst_hi = reg_wdata[HI_W-1:0];
                OFS_LEN:     if (!eng_busy) d.len = reg_wdata[LEN_W-1:0];
                OFS_LEN_AUX: if (!eng_busy) d.len_aux = reg_wdata;
                default: ;
            endcase
        end
        if (eng_done) d.iflag = 1'b1;
        if (d.hard) begin
            d.iflag   = 1'b0;
            d.ien     = 1'b0;
            d.src_lo  = '0;
            d.dst_lo  = '0;
            d.src_hi  = '0;
            d.dst_hi  = '0;
            d.len     = '0;
            d.len_aux = '0;
        end
        abort = warm | d.hard | d.flush;
        start = run_req & ~eng_busy & ~abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_IFLAG:   reg_rdata = {31'b0, q.iflag};
            OFS_IEN:     reg_rdata = {31'b0, q.ien};
            OFS_RUN:     reg_rdata = {31'b0, eng_busy};
            OFS_RST:     reg_rdata = {30'b0, q.hard, 1'b0};
            OFS_FLUSH:   reg_rdata = {31'b0, q.flush};
            OFS_SRC_LO:  reg_rdata = q.src_lo;
            OFS_DST_LO:  reg_rdata = q.dst_lo;
            OFS_SRC_HI:  reg_rdata = 32'(q.src_hi);
            OFS_DST_HI:  reg_rdata = 32'(q.dst_hi);
            OFS_LEN:     reg_rdata = 32'(q.len);
            OFS_LEN_AUX: reg_rdata = q.len_aux;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq      = q.iflag & q.ien;
    assign src_addr = {q.src_hi, q.src_lo};
    assign dst_addr = {q.dst_hi, q.dst_lo};
    assign len      = q.len;

    // R5: a finished copy raises the flag
    a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> q.iflag);

    // R8: setup is frozen while a copy runs
    a_r8_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !q.hard && reg_wr && reg_addr == OFS_SRC_LO) |=> $stable(q.src_lo));

    a_r8_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !q.hard && reg_wr && reg_addr == OFS_LEN) |=> $stable(q.len));

    // R11: a held flush keeps the engine idle
    a_r11_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.flush |-> !eng_busy);

    // R10: a held hard reset keeps the engine idle
    a_r10_hard_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.hard |-> !eng_busy);

endmodule

// File: rtl/dma_copy_chan.sv
module dma_copy_chan
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 28,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NB-1:0]     mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              eng_busy, eng_done, start, abort;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [LEN_W-1:0]  len;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .start     (start),
        .abort     (abort),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .len       (len)
    );

    dma_copy_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .start_src (src_addr),
        .start_dst (dst_addr),
        .start_len (len),
        .busy      (eng_busy),
        .done      (eng_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // R6: interrupt only with flag and enable
    a_r6_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (irq == $past(u_regs.q.ien)) || $past(abort));

endmodule

// File: tb/tb_dma_copy_chan.sv
module tb_dma_copy_chan;
    import dma_copy_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    int proto_fail = 0;
    int addr_fail = 0;
    logic [31:0] exp_hi = '0;
    logic [7:0]  mem [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_copy_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13) + ((a >> 8) * 91) + 7);
    endfunction

    // Memory model: decides each grant half a cycle after the request settles
    initial begin
        bit          pend = 0;
        int          lat = 0;
        int          wcnt = 0;
        logic [63:0] p_addr = '0;
        logic        p_we = 0;
        logic [31:0] p_wdata = '0;
        logic [3:0]  p_be = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (mem_addr[1:0] != 2'b00 || mem_addr[63:32] != exp_hi) addr_fail++;
                if (pend && (mem_addr != p_addr || mem_we != p_we ||
                    (mem_we && (mem_wdata != p_wdata || mem_be != p_be)))) proto_fail++;
                if (wcnt == 0) begin
                    mem_ack = 1'b1;
                    acc_cnt++;
                    for (int b = 0; b < 4; b++) begin
                        logic [8:0] idx;
                        idx = mem_addr[8:0] + 9'(b);
                        if (mem_we) begin
                            if (mem_be[b]) mem[idx] = mem_wdata[8*b +: 8];
                        end else begin
                            mem_rdata[8*b +: 8] = mem[idx];
                        end
                    end
                    pend = 0;
                    lat  = (lat + 1) % 3;
                    wcnt = lat;
                end else begin
                    wcnt--;
                    pend    = 1;
                    p_addr  = mem_addr;
                    p_we    = mem_we;
                    p_wdata = mem_wdata;
                    p_be    = mem_be;
                end
            end else begin
                pend = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(OFS_RUN, v);
            if (v[0] == 1'b0) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 512; i++) mem[i] = pat(i);
    endtask

    task automatic setup(input int src, input int dst, input int len, input logic [31:0] hi);
        exp_hi = hi;
        wr(OFS_RST, 32'h1);
        wr(OFS_SRC_LO, 32'(src));
        wr(OFS_SRC_HI, hi);
        wr(OFS_DST_LO, 32'(dst));
        wr(OFS_DST_HI, hi);
        wr(OFS_LEN, 32'(len));
    endtask

    function automatic int dest_errors(input int src, input int dst, input int len);
        int e = 0;
        for (int a = dst - 8; a < dst + len + 8; a++) begin
            logic [7:0] ex;
            ex = (a >= dst && a < dst + len) ? pat(src + a - dst) : pat(a);
            if (mem[a] != ex) e++;
        end
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int a0, e;
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and readback
        rd(OFS_RUN, v);   chk(v == 0, "R1 run after reset", v, 0);
        rd(OFS_IFLAG, v); chk(v == 0, "R1 flag after reset", v, 0);
        rd(OFS_LEN, v);   chk(v == 0, "R1 len after reset", v, 0);
        chk(irq == 0, "R6 irq after reset", irq, 0);
        wr(OFS_LEN, 32'hFFFF_FFFF);
        rd(OFS_LEN, v);   chk(v == 32'h0FFF_FFFF, "R1 len 28 bits", v, 32'h0FFF_FFFF);
        wr(OFS_SRC_HI, 32'hDEAD_BEEF);
        rd(OFS_SRC_HI, v); chk(v == 32'hDEAD_BEEF, "R1 src high", v, 32'hDEAD_BEEF);
        wr(OFS_LEN_AUX, 32'h1234_5678);
        rd(OFS_LEN_AUX, v); chk(v == 32'h1234_5678, "R1 aux length", v, 32'h1234_5678);

        // R3 R5 R7: sweep of alignments and short lengths
        for (int so = 0; so < 4; so++) begin
            for (int dof = 0; dof < 4; dof++) begin
                for (int ln = 0; ln < 11; ln++) begin
                    init_mem();
                    setup(32'h40 + so, 32'h140 + dof, ln, 0);
                    a0 = acc_cnt;
                    wr(OFS_RUN, 1);
                    wait_idle(ok);
                    chk(ok, "R2 run clears", ok, 1);
                    e = dest_errors(32'h40 + so, 32'h140 + dof, ln);
                    chk(e == 0, "R3 copy bytes", e, 0);
                    rd(OFS_IFLAG, v); chk(v == 1, "R5 flag on done", v, 1);
                    if (ln == 0) chk(acc_cnt == a0, "R7 no access", acc_cnt - a0, 0);
                    wr(OFS_IFLAG, 0);
                end
            end
        end
        rd(OFS_IFLAG, v); chk(v == 0, "R5 flag cleared by 0", v, 0);
        wr(OFS_IFLAG, 1);
        rd(OFS_IFLAG, v); chk(v == 0, "R5 write 1 no effect", v, 0);

        // R2 R8: long copy, setup writes while busy are dropped
        init_mem();
        setup(32'h10, 32'h103, 100, 0);
        wr(OFS_RUN, 1);
        rd(OFS_RUN, v); chk(v == 1, "R2 run reads 1", v, 1);
        wr(OFS_SRC_LO, 32'h1234);
        wr(OFS_LEN, 5);
        rd(OFS_SRC_LO, v); chk(v == 32'h10, "R8 src kept", v, 32'h10);
        rd(OFS_LEN, v);    chk(v == 100, "R8 len kept", v, 100);
        wait_idle(ok);
        e = dest_errors(32'h10, 32'h103, 100);
        chk(e == 0, "R8 copy unaffected", e, 0);

        // R6: interrupt gating
        wr(OFS_IEN, 1);
        @(negedge clk);
        chk(irq == 1, "R6 irq with enable", irq, 1);
        wr(OFS_IEN, 0);
        chk(irq == 0, "R6 irq masked", irq, 0);
        wr(OFS_IFLAG, 0);

        // R9: warm restart abandons the copy
        init_mem();
        setup(32'h8, 32'h100, 200, 0);
        wr(OFS_RUN, 1);
        repeat (6) @(negedge clk);
        wr(OFS_RST, 1);
        rd(OFS_RUN, v); chk(v == 0, "R9 run low", v, 0);
        rd(OFS_RST, v); chk(v == 0, "R9 bit self clears", v, 0);
        a0 = acc_cnt;
        repeat (10) @(negedge clk);
        chk(acc_cnt == a0, "R9 no access", acc_cnt - a0, 0);
        rd(OFS_IFLAG, v);  chk(v == 0, "R9 no flag", v, 0);
        rd(OFS_SRC_LO, v); chk(v == 32'h8, "R9 setup kept", v, 8);

        // R11: flush stops and blocks starts
        setup(32'h8, 32'h100, 200, 0);
        wr(OFS_RUN, 1);
        repeat (4) @(negedge clk);
        wr(OFS_FLUSH, 1);
        rd(OFS_RUN, v); chk(v == 0, "R11 run low", v, 0);
        wr(OFS_RUN, 1);
        rd(OFS_RUN, v); chk(v == 0, "R11 start ignored", v, 0);
        a0 = acc_cnt;
        repeat (5) @(negedge clk);
        chk(acc_cnt == a0, "R11 no access", acc_cnt - a0, 0);
        rd(OFS_FLUSH, v); chk(v == 1, "R11 bit held", v, 1);
        wr(OFS_FLUSH, 0);
        rd(OFS_FLUSH, v); chk(v == 0, "R11 bit cleared", v, 0);
        rd(OFS_IFLAG, v); chk(v == 0, "R11 no flag", v, 0);

        // R10: hard reset wipes setup and blocks starts
        init_mem();
        setup(32'h30, 32'h130, 3, 0);
        wr(OFS_IEN, 1);
        wr(OFS_RUN, 1);
        wait_idle(ok);
        chk(irq == 1, "R6 irq after copy", irq, 1);
        wr(OFS_RST, 2);
        rd(OFS_SRC_LO, v); chk(v == 0, "R10 src cleared", v, 0);
        rd(OFS_LEN, v);    chk(v == 0, "R10 len cleared", v, 0);
        rd(OFS_IEN, v);    chk(v == 0, "R10 ien cleared", v, 0);
        rd(OFS_IFLAG, v);  chk(v == 0, "R10 flag cleared", v, 0);
        rd(OFS_RST, v);    chk(v == 2, "R10 bit held", v, 2);
        chk(irq == 0, "R10 irq low", irq, 0);
        wr(OFS_LEN, 9);
        rd(OFS_LEN, v);    chk(v == 0, "R10 len held at 0", v, 0);
        wr(OFS_RUN, 1);
        rd(OFS_RUN, v);    chk(v == 0, "R10 start ignored", v, 0);
        wr(OFS_RST, 0);

        // R12: high address half reaches the bus
        init_mem();
        setup(32'h21, 32'h1A2, 9, 32'h0000_0005);
        wr(OFS_RUN, 1);
        wait_idle(ok);
        e = dest_errors(32'h21, 32'h1A2, 9);
        chk(e == 0, "R12 copy with high bits", e, 0);
        chk(addr_fail == 0, "R12 address form", addr_fail, 0);
        chk(proto_fail == 0, "R4 request held", proto_fail, 0);

        report();
    end

endmodule